// File: doc/BRIEF.md
# Asynchronous Strobe-Bus Register Slave

This block lets an external microprocessor reach an on-chip register file over an 8-bit asynchronous bus. The bus uses separate active-low read and write strobes, an active-low chip select, an address latch enable and a shared bidirectional data bus. The slave answers each cycle with an active-low ready signal. Inside the chip it offers a plain synchronous register port, timed from the system clock, with address, write data, a one-clock write enable, a one-clock read enable and read data.

Every bus input passes through a multi-stage synchronizer. Edges of the latch enable and the strobes are found in the clock domain. The address is taken when the latch enable falls. A write cycle opens when the write strobe falls, and ready goes low after a parameterised settling time. The data is committed when the strobe rises again, and ready is released one clock later. A read cycle pulses the read enable and takes the returned data. The slave then drives the data onto the bus and lowers ready, and it releases both when the strobe or the select goes away.

Top module: `strobe_bus_slave`

## Requirements
- R1: `reg_addr` takes the value of `bus_addr` exactly SYNC_STAGES+1 clocks after `bus_ale` falls. At all other times it holds its value. It resets to 0.
- R2: A falling write or read strobe while `bus_cs_n` is high starts no cycle. `reg_we` and `reg_re` stay 0 and `bus_rdy_n` stays 1.
- R3: A falling `bus_wr_n` while `bus_cs_n` is low drives `bus_rdy_n` low exactly SYNC_STAGES+1+SETTLE_CLKS clocks later.
- R4: A write is committed only on the rising edge of `bus_wr_n` after ready went low. The commit is a single-clock `reg_we` pulse SYNC_STAGES+1 clocks after the rise. During that pulse `reg_wdata` holds the bus data from the moment of the rise and `reg_addr` holds the latched address.
- R5: `bus_rdy_n` returns high one clock after the `reg_we` pulse.
- R6: A falling `bus_rd_n` while `bus_cs_n` is low gives a one-clock `reg_re` pulse SYNC_STAGES+1 clocks later. The register file answers one clock after `reg_re`, and the slave samples `reg_rdata` two clocks after `reg_re` rises. It drives that value on `bus_data` and pulls `bus_rdy_n` low SYNC_STAGES+1+SETTLE_CLKS clocks after the strobe fell.
- R7: In a read cycle, a rising `bus_rd_n` or a rising `bus_cs_n` releases `bus_data` to high impedance and returns `bus_rdy_n` high, both exactly SYNC_STAGES+1 clocks later. Until then the data stays driven.
- R8: `bus_data` is high impedance whenever no read cycle is active. If `bus_cs_n` rises while a write waits with ready low, the write is abandoned without any `reg_we`, and `bus_rdy_n` returns high SYNC_STAGES+1 clocks after the rise.
- R9: If `bus_wr_n` and `bus_cs_n` rise in the same clock while ready is low, the write is still committed, with the R4 and R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ale | input | 1 | Address latch enable; the address is taken on its falling edge |
| bus_addr | input | ADDR_W (15) | Bus address |
| bus_cs_n | input | 1 | Active-low chip select from external decode |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_data | inout | DATA_W (8) | Bidirectional data bus |
| bus_rdy_n | output | 1 | Active-low ready handshake |
| reg_addr | output | ADDR_W (15) | Latched register address |
| reg_wdata | output | DATA_W (8) | Write data, valid with reg_we |
| reg_we | output | 1 | One-clock write enable |
| reg_re | output | 1 | One-clock read enable |
| reg_rdata | input | DATA_W (8) | Read data, valid one clock after reg_re |

## Verification
Two events can fall in the same clock: the rising write strobe that commits data, and the rising chip select that would otherwise abandon the cycle. The bench raises both inputs on the same clock while ready is low. It expects the commit to win: one `reg_we` pulse carrying the written byte, ready released one clock later, and the byte read back afterwards. A separate write raises only the chip select, and the bench confirms that the register keeps its old value.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSET,
      ST_WWAIT,
      ST_WDONE,
      ST_RSET,
      ST_RWAIT
   } cyc_state_t;

   typedef enum logic {
      EDGE_RISE,
      EDGE_FALL
   } edge_kind_t;

   localparam int unsigned STB_ALE = 0;
   localparam int unsigned STB_CS  = 1;
   localparam int unsigned STB_RD  = 2;
   localparam int unsigned STB_WR  = 3;
   localparam int unsigned STB_CNT = 4;

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sbs_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sbs_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d_in;
         for (int s = 1; s < int'(STAGES); s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q_out = stg[STAGES-1];

endmodule

// File: rtl/sbs_edge.sv
module sbs_edge
   import sbs_pkg::*;
#(
   parameter int unsigned WIDTH = 1,
   parameter edge_kind_t KIND = EDGE_RISE,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] pulse
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign pulse = lvl & ~prev_q;
      end else begin : g_fall
         assign pulse = ~lvl & prev_q;
      end
   endgenerate

endmodule

// File: rtl/sbs_addr_latch.sv
module sbs_addr_latch #(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] addr_s,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= addr_s;
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(addr_q));

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sbs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SETTLE_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lo,
   input  logic              rd_hi,
   input  logic              wr_fall,
   input  logic              wr_rise,
   input  logic              rd_fall,
   input  logic [DATA_W-1:0] data_s,
   input  logic [DATA_W-1:0] rdata,
   output logic              we_q,
   output logic              re_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdq_q,
   output logic              oe_q,
   output logic              rdy_q
);

   localparam int unsigned CNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CLKS - 1);

   cyc_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [1:0]       cap_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         cap_sr  <= '0;
         rdy_q   <= 1'b1;
         we_q    <= 1'b0;
         re_q    <= 1'b0;
         oe_q    <= 1'b0;
         wdata_q <= '0;
         rdq_q   <= '0;
      end else begin
         we_q   <= 1'b0;
         re_q   <= 1'b0;
         cap_sr <= {cap_sr[0], 1'b0};
         if (cap_sr[1]) begin
            rdq_q <= rdata;
            oe_q  <= 1'b1;
         end
         case (st)
            ST_IDLE: begin
               if (cs_lo) begin
                  if (wr_fall) begin
                     st  <= ST_WSET;
                     cnt <= CNT_INIT;
                  end else if (rd_fall) begin
                     st     <= ST_RSET;
                     cnt    <= CNT_INIT;
                     re_q   <= 1'b1;
                     cap_sr <= 2'b01;
                  end
               end
            end
            ST_WSET: begin
               if (!cs_lo || wr_rise) begin
                  st <= ST_IDLE;
               end else if (cnt == '0) begin
                  st    <= ST_WWAIT;
                  rdy_q <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_WWAIT: begin
               if (wr_rise) begin
                  we_q    <= 1'b1;
                  wdata_q <= data_s;
                  st      <= ST_WDONE;
               end else if (!cs_lo) begin
                  st    <= ST_IDLE;
                  rdy_q <= 1'b1;
               end
            end
            ST_WDONE: begin
               rdy_q <= 1'b1;
               st    <= ST_IDLE;
            end
            ST_RSET, ST_RWAIT: begin
               if (rd_hi || !cs_lo) begin
                  st     <= ST_IDLE;
                  rdy_q  <= 1'b1;
                  oe_q   <= 1'b0;
                  cap_sr <= '0;
               end else if (st == ST_RSET) begin
                  if (cnt == '0) begin
                     st    <= ST_RWAIT;
                     rdy_q <= 1'b0;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R4
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);

   // R4
   we_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> !$past(rdy_q));

   // R5
   rdy_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> rdy_q);

   // R6
   re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      re_q |=> !re_q);

   // R7
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && (rd_hi || !cs_lo)) |=> !oe_q);

   // R8
   rdy_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_lo && !$past(cs_lo)) |=> rdy_q);

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
   import sbs_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SETTLE_CLKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ale,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   inout  wire  [DATA_W-1:0] bus_data,
   output logic              bus_rdy_n,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int unsigned PATH_W = ADDR_W + DATA_W;
   localparam logic [STB_CNT-1:0] STB_IDLE = 4'b1110;

   generate
      if (SETTLE_CLKS < 2) begin : g_bad_settle
         $error("strobe_bus_slave: SETTLE_CLKS must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("strobe_bus_slave: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [STB_CNT-1:0] stb_raw, stb_s;
   logic [PATH_W-1:0]  path_raw, path_s;
   logic [ADDR_W-1:0]  addr_s;
   logic [DATA_W-1:0]  data_s;
   logic [2:0]         fall_lvl, fall_p;
   logic [0:0]         rise_lvl, rise_p;
   logic               ale_fall, wr_fall, rd_fall, wr_rise;
   logic               oe, rdy;
   logic [DATA_W-1:0]  drive_val;

   assign stb_raw[STB_ALE] = bus_ale;
   assign stb_raw[STB_CS]  = bus_cs_n;
   assign stb_raw[STB_RD]  = bus_rd_n;
   assign stb_raw[STB_WR]  = bus_wr_n;
   assign path_raw = {bus_addr, bus_data};

   sbs_sync #(.WIDTH(STB_CNT), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d_in(stb_raw), .q_out(stb_s)
   );

   sbs_sync #(.WIDTH(PATH_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_path_sync (
      .clk(clk), .rst_n(rst_n), .d_in(path_raw), .q_out(path_s)
   );

   assign addr_s = path_s[PATH_W-1:DATA_W];
   assign data_s = path_s[DATA_W-1:0];

   assign fall_lvl = {stb_s[STB_WR], stb_s[STB_RD], stb_s[STB_ALE]};
   sbs_edge #(.WIDTH(3), .KIND(EDGE_FALL), .RST_VAL(3'b110)) u_fall (
      .clk(clk), .rst_n(rst_n), .lvl(fall_lvl), .pulse(fall_p)
   );
   assign ale_fall = fall_p[0];
   assign rd_fall  = fall_p[1];
   assign wr_fall  = fall_p[2];

   assign rise_lvl = stb_s[STB_WR];
   sbs_edge #(.WIDTH(1), .KIND(EDGE_RISE), .RST_VAL(1'b1)) u_rise (
      .clk(clk), .rst_n(rst_n), .lvl(rise_lvl), .pulse(rise_p)
   );
   assign wr_rise = rise_p[0];

   sbs_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .take(ale_fall), .addr_s(addr_s), .addr_q(reg_addr)
   );

   sbs_ctrl #(.DATA_W(DATA_W), .SETTLE_CLKS(SETTLE_CLKS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_lo(!stb_s[STB_CS]), .rd_hi(stb_s[STB_RD]),
      .wr_fall(wr_fall), .wr_rise(wr_rise), .rd_fall(rd_fall),
      .data_s(data_s), .rdata(reg_rdata),
      .we_q(reg_we), .re_q(reg_re), .wdata_q(reg_wdata), .rdq_q(drive_val),
      .oe_q(oe), .rdy_q(rdy)
   );

   assign bus_rdy_n = rdy;
   assign bus_data  = oe ? drive_val : {DATA_W{1'bz}};

   // R2
   no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_s[STB_CS] && $past(stb_s[STB_CS])) |=> (!reg_we && !reg_re));

   // R8
   oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !$past(oe)) |-> !stb_s[STB_CS]);

endmodule

// File: tb/test_strobe_bus_slave.sv
`timescale 1ns/1ps
module test_strobe_bus_slave;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int S = 3;
   localparam int LAT = 3;
   localparam int BIG = 1 << 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          tb_drv = 1'b0;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] bus_data;
   assign bus_data = tb_drv ? tb_val : {DW{1'bz}};

   wire           rdy_n, reg_we, reg_re;
   wire  [AW-1:0] reg_addr;
   wire  [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;

   strobe_bus_slave #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .SETTLE_CLKS(S)) i_strobe_bus_slave (
      .clk(clk), .rst_n(rst_n), .bus_ale(ale), .bus_addr(addr), .bus_cs_n(cs_n),
      .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_data(bus_data), .bus_rdy_n(rdy_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_rdata(reg_rdata)
   );

   logic [DW-1:0] mem [64];
   logic [DW-1:0] expv [64];
   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i] = '0;
         expv[i] = '0;
      end
   end
   always @(posedge clk) begin
      if (reg_we) mem[reg_addr[5:0]] <= reg_wdata;
      if (reg_re) reg_rdata <= mem[reg_addr[5:0]];
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nerr = 0;
   int rdy_from = 0, rdy_to = 0, we_at = -1, re_at = -1;
   logic [DW-1:0] exp_wd = '0;
   logic [AW-1:0] exp_wa = '0;
   string mreq = "R3";
   bit mon_on = 1'b0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
      end
   endtask

   // per-clock reference comparison
   always @(negedge clk) begin
      if (mon_on) begin
         chk(mreq, 32'(rdy_n), 32'(!(cyc >= rdy_from && cyc < rdy_to)), "bus_rdy_n");
         chk("R4", 32'(reg_we), 32'(cyc == we_at), "reg_we");
         chk("R6", 32'(reg_re), 32'(cyc == re_at), "reg_re");
         if (reg_we && cyc == we_at) begin
            chk("R4", 32'(reg_wdata), 32'(exp_wd), "reg_wdata");
            chk("R4", 32'(reg_addr), 32'(exp_wa), "reg_addr at commit");
         end
      end
   end

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic probe_free(input string req, input logic [DW-1:0] v);
      tb_drv = 1'b1;
      tb_val = v;
      #1;
      chk(req, 32'(bus_data), 32'(v), "bus_data released");
      tb_drv = 1'b0;
   endtask

   task automatic set_addr(input logic [AW-1:0] a);
      int t0;
      logic [AW-1:0] prev;
      @(negedge clk);
      ale = 1'b1;
      addr = a;
      @(negedge clk);
      ale = 1'b0;
      t0 = cyc;
      prev = reg_addr;
      wait_cyc(t0 + LAT - 1);
      chk("R1", 32'(reg_addr), 32'(prev), "reg_addr before latch");
      wait_cyc(t0 + LAT);
      chk("R1", 32'(reg_addr), 32'(a), "reg_addr after ALE fall");
   endtask

   task automatic wait_rdy_lo(input string req);
      int g = 0;
      while (rdy_n && g < 60) begin
         @(negedge clk);
         g++;
      end
      chk(req, 32'(cyc), 32'(rdy_from), "cycle of ready low");
   endtask

   // mode 0: strobe ends, 1: strobe and select end together, 2: select ends alone
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int mode);
      int t0;
      int tw;
      @(negedge clk);
      cs_n = 1'b0;
      set_addr(a);
      @(negedge clk);
      tb_drv = 1'b1;
      tb_val = d;
      wr_n = 1'b0;
      t0 = cyc;
      mreq = "R3";
      rdy_from = t0 + LAT + S;
      rdy_to = BIG;
      wait_rdy_lo("R3");
      tw = cyc;
      if (mode == 2) begin
         cs_n = 1'b1;
         mreq = "R8";
         rdy_to = tw + LAT;
      end else begin
         wr_n = 1'b1;
         if (mode == 1) begin
            cs_n = 1'b1;
            mreq = "R9";
         end else begin
            mreq = "R5";
         end
         rdy_to = tw + LAT + 1;
         we_at = tw + LAT;
         exp_wd = d;
         exp_wa = a;
         expv[a[5:0]] = d;
      end
      wait_cyc(tw + LAT + 2);
      tb_drv = 1'b0;
      wr_n = 1'b1;
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // mode 0: read strobe ends, 1: select ends
   task automatic do_read(input logic [AW-1:0] a, input int mode);
      int t0;
      int tr;
      logic [DW-1:0] e;
      e = expv[a[5:0]];
      @(negedge clk);
      cs_n = 1'b0;
      set_addr(a);
      @(negedge clk);
      tb_drv = 1'b0;
      rd_n = 1'b0;
      t0 = cyc;
      mreq = "R6";
      re_at = t0 + LAT;
      rdy_from = t0 + LAT + S;
      rdy_to = BIG;
      wait_cyc(t0 + LAT);
      probe_free("R8", 8'h69);
      wait_rdy_lo("R6");
      chk("R6", 32'(bus_data), 32'(e), "bus_data read value");
      tr = cyc;
      if (mode == 0) rd_n = 1'b1;
      else           cs_n = 1'b1;
      mreq = "R7";
      rdy_to = tr + LAT;
      wait_cyc(tr + LAT - 1);
      chk("R7", 32'(bus_data), 32'(e), "bus_data still driven");
      wait_cyc(tr + LAT);
      probe_free("R7", ~e);
      rd_n = 1'b1;
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      reg_rdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", 32'(rdy_n), 32'd1, "bus_rdy_n after reset");
      chk("R1", 32'(reg_addr), 32'd0, "reg_addr after reset");
      chk("R4", 32'(reg_we), 32'd0, "reg_we after reset");
      probe_free("R8", 8'hC3);
      mon_on = 1'b1;

      do_write(15'h1234, 8'hA5, 0);
      do_read(15'h1234, 0);
      do_write(15'h0007, 8'h3C, 0);
      do_read(15'h0007, 1);
      do_write(15'h0011, 8'h5A, 1);   // R9 same-cycle strobe and select release
      do_read(15'h0011, 0);
      do_write(15'h0011, 8'hFF, 2);   // R8 abandoned write keeps 5A
      do_read(15'h0011, 0);

      // R2: strobes without chip select
      mreq = "R2";
      rdy_from = 0;
      rdy_to = 0;
      @(negedge clk);
      tb_drv = 1'b1;
      tb_val = 8'h77;
      wr_n = 1'b0;
      repeat (8) @(negedge clk);
      wr_n = 1'b1;
      tb_drv = 1'b0;
      repeat (4) @(negedge clk);
      rd_n = 1'b0;
      repeat (8) @(negedge clk);
      probe_free("R2", 8'h96);
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      do_read(15'h0007, 0);

      do_write(15'h7FFF, 8'h81, 0);
      do_read(15'h7FFF, 0);
      do_write(15'h0000, 8'h00, 0);
      do_read(15'h0000, 1);

      mon_on = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule